// File: doc/BRIEF.md
# Delegated Interrupt Pending Selector

This block decides which local interrupt a hart should take right now. It looks at the raised interrupt lines, the per-line enables, two delegation masks, the current privilege level, the machine and supervisor global enable bits and a flag that says whether the hart is running a virtualized guest. From these it forms three groups of lines, one per handling level, and qualifies each group by its own global enable. It then picks the surviving line with the lowest index.

The block is purely combinational, so a trap-entry stage can sample the answer in the same cycle as the state it depends on. Its outputs are plain control pins. There is no stream interface, because no data item is handed over and nothing can push back. The vector width is a parameter, 64 by default, and the chosen index is `$clog2` of that width.

Top module: `irq_take_select`

## Requirements
- R1: A line is a candidate only if its bit is set in both `irq_pending` and `irq_enable`; a line with its enable bit clear is never chosen.
- R2: A line whose `mach_deleg` bit is 0 is in the machine group. The group is open when `priv_lvl` is below 3, or when `priv_lvl` is 3 and `m_gie` is 1.
- R3: The supervisor global enable is true when `priv_lvl` is 0, or when `priv_lvl` is 1 and `s_gie` is 1. It is false at privilege 3.
- R4: A line with `mach_deleg`=1 and `hyp_deleg`=0 is in the host-supervisor group. This group is open when `virt_on` is 1 or the supervisor global enable of R3 is true.
- R5: A line with `mach_deleg`=1 and `hyp_deleg`=1 is in the guest-supervisor group. This group is open only when `virt_on` is 1 and the supervisor global enable of R3 is true.
- R6: Among the lines that survive R1 to R5, the one with the lowest index is reported on `take_index`, and `take_valid` is 1.
- R7: When no line survives, `take_valid` is 0 and `take_index` is 0.
- R8: Privilege is coded as 0 = user, 1 = supervisor, 3 = machine. Code 2 follows the numeric comparisons: it counts as below machine, so the machine group is open, and it counts as neither below nor equal to supervisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irq_pending | input | W | Raised interrupt lines |
| irq_enable | input | W | Per-line enable bits |
| mach_deleg | input | W | Lines handed from machine level down to supervisor level |
| hyp_deleg | input | W | Supervisor lines handed further down to the guest |
| priv_lvl | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| virt_on | input | 1 | Hart is running a virtualized guest |
| take_valid | output | 1 | A qualified interrupt exists |
| take_index | output | $clog2(W) | Index of the chosen line, 0 when none |

## Verification
Group qualification and lowest-index selection act in the same cycle. The case that matters is when lines from different groups survive together, or when a low-index line is closed by its group while a higher-index line in another group stays open. The bench sets lines in all three groups at once and sweeps every privilege code, both global enables and the virtualization flag. It judges each cycle against an independent model, which checks both that the right group was gated and that the lowest surviving index was reported.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPV  = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef struct packed {
    logic mach_open;
    logic host_open;
    logic guest_open;
  } group_open_t;
endpackage

// File: rtl/irq_global_gate.sv
module irq_global_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0]  priv_lvl,
  input  logic        m_gie,
  input  logic        s_gie,
  input  logic        virt_on,
  output group_open_t opens
);
  logic mach_glob;
  logic supv_glob;

  always_comb begin
    mach_glob = (priv_lvl < PRIV_MACH) || ((priv_lvl == PRIV_MACH) && m_gie);
    supv_glob = (priv_lvl < PRIV_SUPV) || ((priv_lvl == PRIV_SUPV) && s_gie);
    opens.mach_open  = mach_glob;
    opens.host_open  = virt_on || supv_glob;
    opens.guest_open = virt_on && supv_glob;
  end
endmodule

// File: rtl/irq_group_qualify.sv
module irq_group_qualify
  import irq_sel_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] irq_pending,
  input  logic [W-1:0] irq_enable,
  input  logic [W-1:0] mach_deleg,
  input  logic [W-1:0] hyp_deleg,
  input  group_open_t  opens,
  output logic [W-1:0] survivors
);
  logic [W-1:0] cand;
  logic [W-1:0] grp_mach;
  logic [W-1:0] grp_host;
  logic [W-1:0] grp_guest;

  always_comb begin
    cand      = irq_pending & irq_enable;
    grp_mach  = cand & ~mach_deleg & {W{opens.mach_open}};
    grp_host  = cand & mach_deleg & ~hyp_deleg & {W{opens.host_open}};
    grp_guest = cand & mach_deleg & hyp_deleg & {W{opens.guest_open}};
    survivors = grp_mach | grp_host | grp_guest;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int W = 64
) (
  input  logic [W-1:0]          vec,
  output logic                  any,
  output logic [$clog2(W)-1:0]  idx
);
  localparam int IW = $clog2(W);
  localparam int P  = 1 << IW;

  logic [P-1:0] padded;
  assign padded = P'(vec);

  for (genvar l = 0; l <= IW; l++) begin : g_lvl
    localparam int N = P >> l;
    logic [N-1:0]  v;
    logic [IW-1:0] ix [N];
    if (l == 0) begin : g_leaf
      assign v = padded;
      for (genvar n = 0; n < N; n++) begin : g_n
        assign ix[n] = '0;
      end
    end else begin : g_node
      localparam logic [IW-1:0] HALF = IW'(1) << (l - 1);
      for (genvar n = 0; n < N; n++) begin : g_n
        assign v[n]  = g_lvl[l-1].v[2*n] | g_lvl[l-1].v[2*n+1];
        assign ix[n] = g_lvl[l-1].v[2*n] ? g_lvl[l-1].ix[2*n]
                                         : (g_lvl[l-1].ix[2*n+1] | HALF);
      end
    end
  end

  assign any = g_lvl[IW].v[0];
  assign idx = g_lvl[IW].ix[0];
endmodule

// File: rtl/irq_take_select.sv
module irq_take_select
  import irq_sel_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]         irq_pending,
  input  logic [W-1:0]         irq_enable,
  input  logic [W-1:0]         mach_deleg,
  input  logic [W-1:0]         hyp_deleg,
  input  logic [1:0]           priv_lvl,
  input  logic                 m_gie,
  input  logic                 s_gie,
  input  logic                 virt_on,
  output logic                 take_valid,
  output logic [$clog2(W)-1:0] take_index
);
  localparam int IW = $clog2(W);

  group_open_t   opens;
  logic [W-1:0]  survivors;
  logic          pick_any;
  logic [IW-1:0] pick_idx;

  irq_global_gate u_gate (
    .priv_lvl (priv_lvl),
    .m_gie    (m_gie),
    .s_gie    (s_gie),
    .virt_on  (virt_on),
    .opens    (opens)
  );

  irq_group_qualify #(.W(W)) u_qual (
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .mach_deleg  (mach_deleg),
    .hyp_deleg   (hyp_deleg),
    .opens       (opens),
    .survivors   (survivors)
  );

  irq_lowest_pick #(.W(W)) u_pick (
    .vec (survivors),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign take_valid = pick_any;
  assign take_index = pick_any ? pick_idx : '0;
endmodule

// File: rtl/irq_take_select_chk.sv
module irq_take_select_chk #(
  parameter int W = 64
) (
  input logic [W-1:0]         irq_pending,
  input logic [W-1:0]         irq_enable,
  input logic [W-1:0]         mach_deleg,
  input logic [W-1:0]         hyp_deleg,
  input logic [1:0]           priv_lvl,
  input logic                 m_gie,
  input logic                 s_gie,
  input logic                 virt_on,
  input logic                 take_valid,
  input logic [$clog2(W)-1:0] take_index
);
  always_comb begin
    a_r7_idle_index_zero: assert (take_valid || (take_index == '0));
    a_r1_pick_is_candidate: assert (!take_valid ||
      (irq_pending[take_index] && irq_enable[take_index]));
    a_r2_mach_group_gated: assert (!(take_valid && !mach_deleg[take_index]
      && (priv_lvl == 2'd3)) || m_gie);
    a_r5_guest_needs_virt: assert (!(take_valid && mach_deleg[take_index]
      && hyp_deleg[take_index]) || virt_on);
    a_r3_supv_closed_in_mach: assert (!(take_valid && mach_deleg[take_index]
      && !virt_on) || (priv_lvl != 2'd3));
  end
endmodule

bind irq_take_select irq_take_select_chk #(.W(W)) u_chk (.*);

// File: tb/tb_irq_take_select.sv
module tb_irq_take_select;
  localparam int W  = 64;
  localparam int IW = $clog2(W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [W-1:0]  irq_pending = '0, irq_enable = '0, mach_deleg = '0, hyp_deleg = '0;
  logic [1:0]    priv_lvl = 2'd0;
  logic          m_gie = 1'b0, s_gie = 1'b0, virt_on = 1'b0;
  logic          take_valid;
  logic [IW-1:0] take_index;

  irq_take_select #(.W(W)) dut (.*);

  int compared = 0;
  int mismatched = 0;
  logic [IW:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  function automatic logic [IW:0] model(
    input logic [W-1:0] p, e, md, hd, input logic [1:0] pr,
    input logic mi, si, vo);
    logic mo, so, ho, go;
    logic [W-1:0] s;
    mo = (pr == 2'd3) ? mi : 1'b1;
    so = (pr == 2'd0) ? 1'b1 : ((pr == 2'd1) ? si : 1'b0);
    ho = vo | so;
    go = vo & so;
    s = '0;
    for (int i = 0; i < W; i++) begin
      if (p[i] && e[i]) begin
        if (!md[i]) s[i] = mo;
        else if (!hd[i]) s[i] = ho;
        else s[i] = go;
      end
    end
    for (int i = 0; i < W; i++)
      if (s[i]) return {1'b1, IW'(i)};
    return '0;
  endfunction

  task automatic apply(input logic [W-1:0] p, e, md, hd, input logic [1:0] pr,
                       input logic mi, si, vo, input string tag);
    @(posedge clk);
    #1;
    irq_pending = p; irq_enable = e; mach_deleg = md; hyp_deleg = hd;
    priv_lvl = pr; m_gie = mi; s_gie = si; virt_on = vo;
    exp_q.push_back(model(p, e, md, hd, pr, mi, si, vo));
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [IW:0] ex;
      string tg;
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      compared++;
      if ({take_valid, take_index} !== ex) begin
        mismatched++;
        $display("FAIL %s: actual valid=%0b idx=%0d expected valid=%0b idx=%0d",
                 tg, take_valid, take_index, ex[IW], ex[IW-1:0]);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  localparam logic [W-1:0] Z = '0;
  localparam logic [W-1:0] ONES = '1;

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // R7: quiet state
    apply(Z, Z, Z, Z, 2'd0, 0, 0, 0, "R7 idle");
    // R1: enable gates the pending line
    apply(W'(1) << 5 | W'(1) << 9, W'(1) << 9, Z, Z, 2'd0, 0, 0, 0, "R1 enable mask");
    apply(W'(1) << 5, Z, Z, Z, 2'd3, 1, 1, 0, "R1 disabled only");
    // R2: machine group
    apply(W'(8), ONES, Z, Z, 2'd3, 0, 1, 0, "R2 closed in M");
    apply(W'(8), ONES, Z, Z, 2'd3, 1, 0, 0, "R2 open in M");
    apply(W'(8), ONES, Z, Z, 2'd1, 0, 0, 0, "R2 open below M");
    // R3/R4: host-supervisor group, line 1
    apply(W'(2), ONES, W'(2), Z, 2'd1, 1, 0, 0, "R3 S closed");
    apply(W'(2), ONES, W'(2), Z, 2'd1, 0, 1, 0, "R3 S open");
    apply(W'(2), ONES, W'(2), Z, 2'd0, 0, 0, 0, "R3 U open");
    apply(W'(2), ONES, W'(2), Z, 2'd3, 1, 1, 0, "R3 M closed");
    apply(W'(2), ONES, W'(2), Z, 2'd1, 0, 0, 1, "R4 virt opens host");
    // R5: guest group, line 10
    apply(W'(1) << 10, ONES, W'(1) << 10, W'(1) << 10, 2'd1, 0, 1, 1, "R5 open");
    apply(W'(1) << 10, ONES, W'(1) << 10, W'(1) << 10, 2'd0, 0, 0, 0, "R5 no virt");
    apply(W'(1) << 10, ONES, W'(1) << 10, W'(1) << 10, 2'd0, 0, 0, 1, "R5 U virt");
    apply(W'(1) << 10, ONES, W'(1) << 10, W'(1) << 10, 2'd1, 0, 0, 1, "R5 S sie off");
    // R6: lowest index, cross-group
    apply(W'(1) << 7 | W'(1) << 40, ONES, Z, Z, 2'd0, 0, 0, 0, "R6 lowest");
    apply(W'(1) << 63, ONES, Z, Z, 2'd0, 0, 0, 0, "R6 top line");
    apply(W'(3), ONES, W'(1), W'(1), 2'd3, 1, 1, 1, "R6 low line closed");
    // R8: reserved privilege code 2
    apply(W'(4), ONES, Z, Z, 2'd2, 0, 0, 0, "R8 mach open at 2");
    apply(W'(4), ONES, W'(4), Z, 2'd2, 0, 1, 0, "R8 host closed at 2");
    // R6 sweep: all privilege, enable and virt combinations with random vectors
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 40; k++) begin
        logic [W-1:0] p, e, md, hd;
        p  = {$urandom, $urandom} & {$urandom, $urandom};
        e  = {$urandom, $urandom};
        md = {$urandom, $urandom};
        hd = {$urandom, $urandom};
        apply(p, e, md, hd, c[1:0], c[2], c[3], c[4], "R6 sweep");
      end
    end
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule